// File: doc/BRIEF.md
# UART Transmitter with Selectable Parity

This block turns bytes into asynchronous serial frames on a single output line. Software-side logic writes bytes into a small internal queue. Whenever the queue holds data, the block pops one byte and sends a frame. A frame is a low start bit, eight data bits with the least significant bit first, an optional parity bit, and one high stop bit. When nothing is queued, the line rests high.

Bit timing comes from a programmable 16-bit clock divisor, which produces oversample ticks. Each bit lasts either 8 or 16 of these ticks. At the start of each frame the block captures the parity selection, the oversampling choice and the divisor. A change on those inputs therefore affects only later frames. After each stop bit the block raises a one-cycle completion pulse. Queued bytes leave as a continuous stream with no idle time between frames.

Top module: `uart_tx_par`

## Requirements
- R1: While reset is asserted and after it is released with nothing written, txLine is 1, fifoEmpty is 1, fifoFull is 0 and txDone is 0.
- R2: A frame is txLine=0 for one bit time, then data bits 0 through 7 in that order, then an optional parity bit, then txLine=1 for one bit time. Each bit time is exactly osf*max(divisor,1) clock cycles, where osf is the oversampling factor.
- R3: parityMode 0 sends no parity bit. parityMode 1 sends a bit that makes the count of ones in data plus parity even. parityMode 2 makes that count odd. parityMode 3 behaves as 0.
- R4: overSel=0 selects osf=16 ticks per bit, and overSel=1 selects osf=8.
- R5: An oversample tick occurs every max(divisor,1) clocks, so a divisor of 0 times bits exactly as a divisor of 1.
- R6: txDone is high for exactly one cycle, the first cycle after the stop bit's last cycle, and is low at all other times.
- R7: A frame starts only when the queue is non-empty. If the queue is non-empty when a stop bit ends, the next start bit begins in the very next cycle.
- R8: The queue holds DEPTH bytes. fifoEmpty is high exactly when it holds none, and fifoFull is high exactly when it holds DEPTH. A write while fifoFull is high is dropped and never transmitted.
- R9: parityMode, overSel and divisor are sampled when a frame starts. Changes during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the transmit queue |
| wrData | input | 8 | Byte to queue |
| divisor | input | 16 | Clocks per oversample tick (0 treated as 1) |
| overSel | input | 1 | 0: 16 ticks per bit, 1: 8 ticks per bit |
| parityMode | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| txLine | output | 1 | Serial output, idles high |
| txDone | output | 1 | One-cycle pulse after each stop bit |
| fifoEmpty | output | 1 | Queue holds no bytes |
| fifoFull | output | 1 | Queue holds DEPTH bytes |

## Verification
A wrong bit counter or state shows up as a frame that is too long or too short. The bench checks the line in the first and last cycle of every bit, so such an error is caught within one bit time, at the parity or stop position. A wrong tick or oversample count stretches or shrinks the start bit, which is caught at the start bit's last cycle. A corrupt queue count appears on fifoEmpty or fifoFull in the next cycle. It also shows up as a missing, repeated or extra frame, which the scoreboard catches at that frame's start bit.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PARITY, S_STOP
  } txState_e;

  typedef enum logic [1:0] {
    L_MARK, L_SPACE, L_DATA, L_PAR
  } lineSel_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic     pop;     // take head byte, load shifter
    logic     shift;   // advance to next data bit
    logic     oddPar;  // parity flavour for the byte being loaded
    lineSel_e lineSel; // what drives the line
  } txStrobe_t;
endpackage

// File: rtl/utx_datapath.sv
module utx_datapath
  import utx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  txStrobe_t         strb,
  output logic              txLine,
  output logic              fifoEmpty,
  output logic              fifoFull
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [CW-1:0]     count;
  logic [DATA_W-1:0] shiftReg;
  logic              parBit;
  logic              push;

  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count == CW'(DEPTH));
  assign push      = wrEn && !fifoFull;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push)     wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (strb.pop) rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
      parBit   <= 1'b1;
    end else if (strb.pop) begin
      shiftReg <= mem[rdPtr];
      parBit   <= (^mem[rdPtr]) ^ strb.oddPar;
    end else if (strb.shift) begin
      shiftReg <= {1'b1, shiftReg[DATA_W-1:1]};
    end
  end

  always_comb begin
    case (strb.lineSel)
      L_SPACE: txLine = 1'b0;
      L_DATA:  txLine = shiftReg[0];
      L_PAR:   txLine = parBit;
      default: txLine = 1'b1;
    endcase
  end
endmodule

// File: rtl/utx_ctrl.sv
module utx_ctrl
  import utx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEmpty,
  input  logic [DIV_W-1:0] divisor,
  input  logic             overSel,
  input  logic [1:0]       parityMode,
  output txStrobe_t        strb,
  output logic             txDone
);
  localparam int BIT_CW = $clog2(DATA_W);

  txState_e          state;
  logic [DIV_W-1:0]  divCnt, divLat, effDiv;
  logic [3:0]        osCnt;
  logic [BIT_CW-1:0] bitCnt;
  logic [1:0]        parLat;
  logic              os8Lat;
  logic              tick, lastOs, bitEnd, startNow, parOn;

  assign effDiv   = (divisor == '0) ? DIV_W'(1) : divisor;
  assign tick     = (state != S_IDLE) && (divCnt == '0);
  assign lastOs   = os8Lat ? (osCnt == 4'd7) : (osCnt == 4'd15);
  assign bitEnd   = tick && lastOs;
  assign parOn    = (parLat == 2'd1) || (parLat == 2'd2);
  assign startNow = !fifoEmpty &&
                    ((state == S_IDLE) || ((state == S_STOP) && bitEnd));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      divCnt <= '0;
      divLat <= '0;
      osCnt  <= '0;
      bitCnt <= '0;
      parLat <= '0;
      os8Lat <= 1'b0;
      txDone <= 1'b0;
    end else begin
      txDone <= (state == S_STOP) && bitEnd;
      if (startNow) begin
        state  <= S_START;
        parLat <= parityMode;
        os8Lat <= overSel;
        divLat <= effDiv - 1'b1;
        divCnt <= effDiv - 1'b1;
        osCnt  <= '0;
      end else if (state != S_IDLE) begin
        if (tick) begin
          divCnt <= divLat;
          osCnt  <= lastOs ? 4'd0 : osCnt + 4'd1;
        end else begin
          divCnt <= divCnt - 1'b1;
        end
        if (bitEnd) begin
          case (state)
            S_START: begin
              state  <= S_DATA;
              bitCnt <= '0;
            end
            S_DATA: begin
              if (bitCnt == BIT_CW'(DATA_W - 1)) state <= parOn ? S_PARITY : S_STOP;
              else bitCnt <= bitCnt + 1'b1;
            end
            S_PARITY: state <= S_STOP;
            default:  state <= S_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    strb.pop    = startNow;
    strb.shift  = (state == S_DATA) && bitEnd;
    strb.oddPar = (parityMode == 2'd2);
    case (state)
      S_START:  strb.lineSel = L_SPACE;
      S_DATA:   strb.lineSel = L_DATA;
      S_PARITY: strb.lineSel = L_PAR;
      default:  strb.lineSel = L_MARK;
    endcase
  end
endmodule

// File: rtl/uart_tx_par.sv
module uart_tx_par
  import utx_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              overSel,
  input  logic [1:0]        parityMode,
  output logic              txLine,
  output logic              txDone,
  output logic              fifoEmpty,
  output logic              fifoFull
);
  txStrobe_t strb;
  logic      popStb;

  assign popStb = strb.pop;

  utx_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty), .divisor(divisor),
    .overSel(overSel), .parityMode(parityMode), .strb(strb), .txDone(txDone)
  );

  utx_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .strb(strb),
    .txLine(txLine), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull)
  );
endmodule

// File: rtl/utx_checker.sv
module utx_checker (
  input logic clk,
  input logic rstN,
  input logic txLine,
  input logic txDone,
  input logic fifoEmpty,
  input logic fifoFull,
  input logic wrEn,
  input logic popStb
);
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoEmpty && fifoFull));

  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && !popStb) |=> fifoFull);

  a_r8_empty_holds: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEmpty && !wrEn) |=> fifoEmpty);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !txDone);

  a_r6_done_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txDone) |-> $past(txLine));

  a_r7_pop_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    popStb |-> !fifoEmpty);
endmodule

bind uart_tx_par utx_checker u_chk (
  .clk(clk), .rstN(rstN), .txLine(txLine), .txDone(txDone),
  .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .wrEn(wrEn), .popStb(popStb)
);

// File: tb/sim_uart_tx_par.sv
`timescale 1ns/1ps
module sim_uart_tx_par;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [15:0] divisor = 16'd1;
  logic        overSel = 1'b0;
  logic [1:0]  parityMode = 2'd0;
  logic        txLine, txDone, fifoEmpty, fifoFull;

  always #4 clk = ~clk;

  uart_tx_par u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .divisor(divisor),
    .overSel(overSel), .parityMode(parityMode), .txLine(txLine),
    .txDone(txDone), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull)
  );

  typedef struct {
    logic [7:0] data;
    logic [1:0] par;
    logic       os8;
    int         div;
    bit         chained;
    string      tag;
  } item_t;

  item_t q[$];
  int compared = 0, mismatched = 0;
  int framesPushed = 0, framesSeen = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // driver: called at a negedge, leaves at the next negedge
  task automatic push(input logic [7:0] d, input logic [1:0] p, input logic o8,
                      input int dv, input bit ch, input string tag);
    item_t it;
    it.data = d; it.par = p; it.os8 = o8; it.div = dv; it.chained = ch; it.tag = tag;
    q.push_back(it);
    framesPushed++;
    parityMode = p; overSel = o8; divisor = 16'(dv);
    wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitIdle();
    while (framesSeen != framesPushed) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin : monitor
    bit pend;
    item_t it;
    logic bits [11];
    int n, bt;
    pend = 0;
    forever begin
      if (!pend) @(negedge clk);
      pend = 0;
      if (rstN && txLine === 1'b0) begin
        if (q.size() == 0) begin
          check(0, "R8 unexpected frame (dropped byte sent)", 1, 0);
          while (txLine !== 1'b1) @(negedge clk);
        end else begin
          it = q.pop_front();
          bt = (it.os8 ? 8 : 16) * ((it.div == 0) ? 1 : it.div);
          bits[0] = 1'b0;
          for (int i = 0; i < 8; i++) bits[i+1] = it.data[i];
          n = 9;
          if (it.par == 2'd1)      begin bits[n] = ^it.data;  n++; end
          else if (it.par == 2'd2) begin bits[n] = ~^it.data; n++; end
          bits[n] = 1'b1; n++;
          for (int i = 0; i < n; i++) begin
            for (int c = 0; c < bt; c++) begin
              if (c == 0 || c == bt - 1)
                check(txLine === bits[i],
                      $sformatf("%s R2 frame bit %0d cycle %0d (n=%0d, R3 parity)", it.tag, i, c, n),
                      int'(txLine), int'(bits[i]));
              if (i == n - 1 && c == bt - 1)
                check(txDone === 1'b0, "R6 txDone early", int'(txDone), 0);
              @(negedge clk);
            end
          end
          check(txDone === 1'b1, $sformatf("%s R6 txDone after stop", it.tag), int'(txDone), 1);
          framesSeen++;
          if (q.size() > 0 && q[0].chained)
            check(txLine === 1'b0, "R7 gapless next start", int'(txLine), 0);
          if (txLine === 1'b0) pend = 1;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    summary();
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    // R1 during reset
    check(txLine === 1'b1,    "R1 txLine in reset",    int'(txLine), 1);
    check(fifoEmpty === 1'b1, "R1 fifoEmpty in reset", int'(fifoEmpty), 1);
    check(fifoFull === 1'b0,  "R1 fifoFull in reset",  int'(fifoFull), 0);
    check(txDone === 1'b0,    "R1 txDone in reset",    int'(txDone), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(txLine === 1'b1,    "R1 R7 idle line without data", int'(txLine), 1);
    check(fifoEmpty === 1'b1, "R1 fifoEmpty idle", int'(fifoEmpty), 1);

    // R2, R4 (16x), R5: divisor 1, no parity
    push(8'hA5, 2'd0, 1'b0, 1, 0, "R4");
    waitIdle();
    // R3 even parity, R4 8x, divisor 2
    push(8'h3C, 2'd1, 1'b1, 2, 0, "R3");
    waitIdle();
    push(8'h07, 2'd1, 1'b1, 1, 0, "R3");
    waitIdle();
    // R3 odd parity, R5 divisor 0 acts as 1
    push(8'h01, 2'd2, 1'b1, 0, 0, "R5");
    waitIdle();
    push(8'hFF, 2'd2, 1'b0, 1, 0, "R3");
    waitIdle();
    // R3 code 3 behaves as none, divisor 3
    push(8'h80, 2'd3, 1'b0, 3, 0, "R3");
    waitIdle();

    // R7 / R8: burst that fills the queue, then one dropped write
    push(8'h11, 2'd1, 1'b1, 1, 0, "R7");
    push(8'h22, 2'd1, 1'b1, 1, 1, "R7");
    push(8'h33, 2'd1, 1'b1, 1, 1, "R7");
    check(fifoFull === 1'b0, "R8 not full at 2 entries", int'(fifoFull), 0);
    push(8'h44, 2'd1, 1'b1, 1, 1, "R7");
    push(8'h55, 2'd1, 1'b1, 1, 1, "R7");
    check(fifoFull === 1'b1,  "R8 full at DEPTH", int'(fifoFull), 1);
    check(fifoEmpty === 1'b0, "R8 not empty when full", int'(fifoEmpty), 0);
    wrData = 8'hEE; wrEn = 1'b1;  // dropped write
    @(negedge clk);
    wrEn = 1'b0;
    check(fifoFull === 1'b1, "R8 full after dropped write", int'(fifoFull), 1);
    waitIdle();
    repeat (100) @(negedge clk);
    check(fifoEmpty === 1'b1, "R8 empty after drain", int'(fifoEmpty), 1);
    check(txLine === 1'b1,    "R8 no frame for dropped byte", int'(txLine), 1);

    // R9: settings changed mid-frame apply only to the next frame
    push(8'h5A, 2'd0, 1'b1, 2, 0, "R9");
    repeat (10) @(negedge clk);
    parityMode = 2'd2; overSel = 1'b0; divisor = 16'd1;
    waitIdle();
    push(8'hC3, 2'd2, 1'b0, 1, 0, "R9");
    waitIdle();

    check(q.size() == 0, "R7 all queued frames sent", q.size(), 0);
    check(txLine === 1'b1, "R1 line idle at end", int'(txLine), 1);
    summary();
  end
endmodule